// File: doc/BRIEF.md
# Dual-Clock FIFO with Read Rewind

This block is a first-in first-out buffer between two unrelated clock domains. Words enter on the write clock and leave on the read clock through a simple dual-port memory. A packet that has been read can be read again: a rewind pulse on the read side moves the read position back to the first memory slot, and stored words and the write position are left as they are. The sender and receiver agree on where each packet starts.

Both flags come from registers that only advance on enabled edges. The empty status is captured in the write domain whenever write enable is high. It is then captured again in the read domain whenever read enable is high, and only that second register can gate the memory read. The full status is kept in one write-domain register that updates only when write enable is high, and it gates the memory write. So the first word out of an empty buffer always takes a fixed number of enabled read edges, and the first write after a full spell costs one dead write cycle. A build-time switch adds an output register, which adds one more read-enabled edge to the first-word latency.

Top module: `dcfifo_replay`

## Requirements
- R1: While `rstN` is low and right after it rises, `emptyFlag` is 1, `fullFlag` is 0, `rdData` is all zeros, and both read and write positions are at slot 0.
- R2: On a `wrClk` rising edge with `wrEn` high and `fullFlag` low, `wrData` is stored and the write position advances by one. Words leave in the order they were accepted.
- R3: A `rdClk` rising edge with `rdRewind` high moves the read position to slot 0 with the wrap bit clear, and no read happens on that edge. Stored words and the write position do not change, so the words already read come out again in the same order and a word written afterwards follows them.
- R4: `emptyFlag` changes only on `rdClk` edges with `rdEn` high. After such an edge it is 1 exactly when no unread word remains.
- R5: A memory read takes place on a `rdClk` edge where `rdEn` is high and `emptyFlag` was 0 just before that edge. With `OUT_REG`=0, `rdData` shows the word read from that edge onward. The first word after empty therefore appears on the second read-enabled edge.
- R6: With `OUT_REG`=1, the output register loads the memory output on every `rdClk` edge with `rdEn` high. The first word after empty appears on the third read-enabled edge.
- R7: `fullFlag` changes only on `wrClk` edges with `wrEn` high, and it becomes 1 on the edge that stores the 2^`ADDR_W`-th unread word. A write while `fullFlag` is 1 stores nothing. The first write-enabled edge after space is freed only clears the flag, and the next one stores.
- R8: A read-enabled edge while `emptyFlag` is 1 leaves the read position and the unregistered `rdData` unchanged.
- R9: `rdData` does not change on any `rdClk` edge with `rdEn` low, in either output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrEn | input | 1 | Write request, sampled on `wrClk` |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Read request, sampled on `rdClk` |
| rdRewind | input | 1 | Returns the read position to slot 0 for retransmit |
| rdData | output | DATA_W | Read word, registered once or twice depending on `OUT_REG` |
| emptyFlag | output | 1 | Read-domain empty status |
| fullFlag | output | 1 | Write-domain full status |

## Verification
One word written into an empty buffer and then read with a run of read-enabled edges separates the two-edge and three-edge first-word latencies. This is done with one instance per output mode on the same stimulus. A fill to exactly the buffer depth, followed by an extra write and a full drain with extra reads, shows where the full and empty flags switch. It also shows that the writes refused while full and the reads refused while empty are really dropped, and the word written after the dead write cycle proves which write was kept. A five-word packet is read, rewound, read again and then followed by one new word, which tells a correct replay apart from a rewind that disturbs the write side. A long stream with unrelated clock periods and irregular enable patterns is compared against a queue in the bench, so ordering or wrap errors show up under random-looking interleaving.

// File: rtl/dcfifo_replay_pkg.sv
package dcfifo_replay_pkg;

  // strobes from the control section to the storage section
  typedef struct packed {
    logic wrStb;    // store wrData at the write address
    logic rdStb;    // fetch the word at the read address
    logic loadOut;  // advance the optional output register
  } memStb_t;

endpackage

// File: rtl/dcfifo_replay_ctrl.sv
module dcfifo_replay_ctrl
  import dcfifo_replay_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              rdRewind,
  output memStb_t           stb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              emptyFlag,
  output logic              fullFlag
);

  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrNext, rdPtrNext;
  logic wEmpty, wFull, rEmpty;
  logic intWr, intRd;

  function automatic logic ptrFull(input logic [PTR_W-1:0] a, input logic [PTR_W-1:0] b);
    return (a[ADDR_W-1:0] == b[ADDR_W-1:0]) && (a[ADDR_W] != b[ADDR_W]);
  endfunction

  // memory strobes gated by the enable-qualified flag registers
  assign intWr = wrEn & ~wFull;
  assign intRd = rdEn & ~rEmpty & ~rdRewind;

  assign wrPtrNext = wrPtr + PTR_W'(intWr);
  assign rdPtrNext = rdRewind ? '0 : (rdPtr + PTR_W'(intRd));

  // write domain: pointer, captured empty status, full status
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      wEmpty <= 1'b1;
      wFull  <= 1'b0;
    end else if (wrEn) begin
      wrPtr  <= wrPtrNext;
      wEmpty <= (wrPtrNext == rdPtr);
      wFull  <= ptrFull(wrPtrNext, rdPtr);
    end
  end

  // read domain: pointer and second empty stage
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr  <= '0;
      rEmpty <= 1'b1;
    end else begin
      if (intRd || rdRewind) rdPtr <= rdPtrNext;
      if (rdEn) rEmpty <= wEmpty | (wrPtr == rdPtrNext);
    end
  end

  assign stb.wrStb   = intWr;
  assign stb.rdStb   = intRd;
  assign stb.loadOut = rdEn;
  assign wrAddr      = wrPtr[ADDR_W-1:0];
  assign rdAddr      = rdPtr[ADDR_W-1:0];
  assign emptyFlag   = rEmpty;
  assign fullFlag    = wFull;

endmodule

// File: rtl/dcfifo_replay_dpath.sv
module dcfifo_replay_dpath
  import dcfifo_replay_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  memStb_t           stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramQ;

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) mem[wrAddr] <= wrData;
  end

  // synchronous read port
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)          ramQ <= '0;
    else if (stb.rdStb) ramQ <= mem[rdAddr];
  end

  generate
    if (OUT_REG) begin : gOutReg
      logic [DATA_W-1:0] outQ;
      always_ff @(posedge rdClk or negedge rstN) begin
        if (!rstN)            outQ <= '0;
        else if (stb.loadOut) outQ <= ramQ;
      end
      assign rdData = outQ;
    end else begin : gNoOutReg
      assign rdData = ramQ;
    end
  endgenerate

endmodule

// File: rtl/dcfifo_replay.sv
module dcfifo_replay
  import dcfifo_replay_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              rdRewind,
  output logic [DATA_W-1:0] rdData,
  output logic              emptyFlag,
  output logic              fullFlag
);

  memStb_t           stb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  dcfifo_replay_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .wrClk    (wrClk),
    .rdClk    (rdClk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .rdRewind (rdRewind),
    .stb      (stb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .emptyFlag(emptyFlag),
    .fullFlag (fullFlag)
  );

  dcfifo_replay_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) dpath_i (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .rstN   (rstN),
    .stb    (stb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

endmodule

// File: rtl/dcfifo_replay_chk.sv
module dcfifo_replay_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic              rdRewind,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              emptyFlag,
  input logic              fullFlag
);

  // R2: an accepted write moves the write slot by exactly one
  a_r2_write_advances: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && !fullFlag) |=> (wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));

  // R7: a write attempted while full leaves the write slot alone
  a_r7_no_overflow: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && fullFlag) |=> $stable(wrAddr));

  // R3: rewind lands on slot 0
  a_r3_rewind_to_zero: assert property (@(posedge rdClk) disable iff (!rstN)
    rdRewind |=> (rdAddr == '0));

  // R8: a read attempted while empty moves nothing
  a_r8_no_underflow: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && emptyFlag && !rdRewind) |=> $stable(rdAddr));

  // R9: output holds on edges without read enable
  a_r9_hold_output: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind dcfifo_replay dcfifo_replay_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/dcfifo_replay_tb_top.sv
`timescale 1ns/1ps
module dcfifo_replay_tb_top;

  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic rstN, wrEn, rdEn, rdRewind;
  logic [DW-1:0] wrData;
  logic [DW-1:0] rdDataA, rdDataB;
  logic emptyA, fullA, emptyB, fullB;

  int vectors = 0;
  int miscompares = 0;
  logic [DW-1:0] refQ[$];

  always #4    wrClk = ~wrClk;   // 125 MHz
  always #5.65 rdClk = ~rdClk;   // unrelated read clock

  dcfifo_replay #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b0)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdRewind(rdRewind), .rdData(rdDataA), .emptyFlag(emptyA), .fullFlag(fullA));

  dcfifo_replay #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b1)) dut_reg_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdRewind(rdRewind), .rdData(rdDataB), .emptyFlag(emptyB), .fullFlag(fullB));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic wrStep(input logic en, input logic [DW-1:0] d);
    @(negedge wrClk);
    wrEn = en; wrData = d;
    @(posedge wrClk); #1;
  endtask

  task automatic rdStep(input logic en, input logic rew);
    @(negedge rdClk);
    rdEn = en; rdRewind = rew;
    @(posedge rdClk); #1;
  endtask

  task automatic doReset();
    @(negedge wrClk);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; rdRewind = 1'b0;
    #30;
    rstN = 1'b1;
    #25;
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; rdRewind = 1'b0; wrData = '0;
    #40;
    chk(emptyA == 1'b1 && emptyB == 1'b1, "R1 empty in reset", emptyA, 1);
    chk(fullA == 1'b0 && fullB == 1'b0, "R1 full in reset", fullA, 0);
    rstN = 1'b1;
    #25;
    chk(rdDataA == '0 && rdDataB == '0, "R1 data after reset", rdDataA, 0);

    // ---- first-word latency, both output modes ----
    wrStep(1'b1, 8'hA5);
    wrStep(1'b0, 8'h00);
    repeat (3) rdStep(1'b0, 1'b0);
    chk(emptyA == 1'b1, "R4 empty holds without rdEn", emptyA, 1);
    rdStep(1'b1, 1'b0);
    chk(emptyA == 1'b0, "R4 empty clears on first rdEn edge", emptyA, 0);
    chk(rdDataA == 8'h00, "R5 no data after first edge", rdDataA, 0);
    rdStep(1'b1, 1'b0);
    chk(rdDataA == 8'hA5, "R5 unregistered data on second edge", rdDataA, 8'hA5);
    chk(rdDataB == 8'h00, "R6 registered data not yet on second edge", rdDataB, 0);
    chk(emptyA == 1'b1, "R4 empty after last word", emptyA, 1);
    rdStep(1'b1, 1'b0);
    chk(rdDataB == 8'hA5, "R6 registered data on third edge", rdDataB, 8'hA5);
    chk(rdDataA == 8'hA5, "R8 read while empty keeps output", rdDataA, 8'hA5);
    repeat (2) rdStep(1'b0, 1'b0);
    chk(rdDataB == 8'hA5, "R9 registered output holds", rdDataB, 8'hA5);

    // ---- fill to depth, overflow attempt, drain ----
    for (int i = 0; i < DEPTH; i++) begin
      wrStep(1'b1, 8'(8'h40 + i));
      if (i == DEPTH - 2) chk(fullA == 1'b0, "R7 not full one short", fullA, 0);
    end
    chk(fullA == 1'b1, "R7 full at depth", fullA, 1);
    wrStep(1'b1, 8'hEE);
    chk(fullA == 1'b1, "R7 full holds on refused write", fullA, 1);
    wrStep(1'b0, 8'h00);
    rdStep(1'b1, 1'b0);
    for (int k = 0; k < DEPTH; k++) begin
      rdStep(1'b1, 1'b0);
      chk(rdDataA == 8'(8'h40 + k), "R2 drain order", rdDataA, 8'h40 + k);
      if (k >= 1) chk(rdDataB == 8'(8'h40 + k - 1), "R6 registered drain order", rdDataB, 8'h40 + k - 1);
    end
    chk(emptyA == 1'b1, "R4 empty after drain", emptyA, 1);
    rdStep(1'b1, 1'b0);
    chk(rdDataB == 8'h47, "R6 registered last word", rdDataB, 8'h47);
    chk(rdDataA == 8'h47, "R8 extra read ignored", rdDataA, 8'h47);
    rdStep(1'b0, 1'b0);
    chk(fullA == 1'b1, "R7 full stale until wrEn", fullA, 1);
    wrStep(1'b1, 8'h11);
    chk(fullA == 1'b0, "R7 dead write clears full", fullA, 0);
    wrStep(1'b1, 8'h3C);
    wrStep(1'b0, 8'h00);
    rdStep(1'b1, 1'b0);
    rdStep(1'b1, 1'b0);
    chk(rdDataA == 8'h3C, "R7 dropped writes not stored", rdDataA, 8'h3C);
    rdStep(1'b1, 1'b0);
    chk(emptyA == 1'b1, "R8 empty after single word", emptyA, 1);
    rdStep(1'b0, 1'b0);

    // ---- retransmit ----
    doReset();
    for (int i = 0; i < 5; i++) wrStep(1'b1, 8'(8'h90 + i));
    wrStep(1'b0, 8'h00);
    rdStep(1'b1, 1'b0);
    for (int k = 0; k < 5; k++) begin
      rdStep(1'b1, 1'b0);
      chk(rdDataA == 8'(8'h90 + k), "R2 packet first pass", rdDataA, 8'h90 + k);
    end
    rdStep(1'b0, 1'b1);
    chk(rdDataA == 8'h94, "R3 rewind edge reads nothing", rdDataA, 8'h94);
    rdStep(1'b1, 1'b0);
    chk(emptyA == 1'b0, "R3 data available after rewind", emptyA, 0);
    for (int k = 0; k < 5; k++) begin
      rdStep(1'b1, 1'b0);
      chk(rdDataA == 8'(8'h90 + k), "R3 replay matches", rdDataA, 8'h90 + k);
    end
    chk(emptyA == 1'b1, "R3 empty after replay", emptyA, 1);
    rdStep(1'b0, 1'b0);
    wrStep(1'b1, 8'h77);
    wrStep(1'b0, 8'h00);
    rdStep(1'b1, 1'b0);
    rdStep(1'b1, 1'b0);
    chk(rdDataA == 8'h77, "R3 write position kept across rewind", rdDataA, 8'h77);
    rdStep(1'b0, 1'b0);

    // ---- streaming with unrelated clocks ----
    doReset();
    refQ.delete();
    fork
      begin
        int sent = 0;
        int cyc = 0;
        while (sent < 40) begin
          @(negedge wrClk);
          wrEn = ((cyc % 5) != 2);
          wrData = 8'(sent * 7 + 3);
          if (wrEn && !fullA) begin
            refQ.push_back(wrData);
            sent++;
          end
          cyc++;
        end
        @(negedge wrClk);
        wrEn = 1'b0;
      end
      begin
        int got = 0;
        int cyc = 0;
        while (got < 40 && cyc < 4000) begin
          logic willRd;
          @(negedge rdClk);
          rdEn = ((cyc % 4) != 1);
          willRd = rdEn && !emptyA;
          @(posedge rdClk); #1;
          if (willRd) begin
            logic [DW-1:0] exp;
            exp = (refQ.size() > 0) ? refQ.pop_front() : 8'hXX;
            chk(rdDataA == exp, "R5 stream word", rdDataA, exp);
            got++;
          end
          cyc++;
        end
        chk(got == 40, "R2 stream count", got, 40);
        @(negedge rdClk);
        rdEn = 1'b0;
      end
    join

    finishRun();
  end

endmodule